// File: doc/BRIEF.md
# Setup-Frame Loaded Address Filter

This block decides, for every received Ethernet frame, whether the frame is kept or dropped, based on the 48-bit destination address. The table of station addresses it matches against is loaded from a 192-byte setup frame, which arrives one byte per cycle on a simple valid/byte stream. The frame is split into 16 slots of 12 bytes. From each slot, six bytes are taken from three byte pairs to form one address.

A slot whose address has the group bit set is skipped. Every unicast address is appended to the table in slot order, and the table fill count starts again from zero with each new setup frame. Only entries below the fill count can match. Entries left over from an earlier, longer load therefore stop matching after a shorter load.

Filtering is a one-cycle lookup. When lookup_ready is high, a destination strobe gives a registered verdict on the next cycle. Promiscuous mode accepts everything, and group (multicast and broadcast) destinations are always accepted. Any other destination is accepted only if it equals a live table entry. While a setup frame is being received, including pauses in the middle of the frame, lookups are refused.

Top module: `setup_addr_filter`

## Requirements
- R1: A setup frame is exactly 192 bytes (16 slots of 12 bytes), counted on cycles with setup_valid high; the frame counter holds during gaps and wraps after byte 191, so the next setup byte starts a new frame.
- R2: Within a slot, address bytes are taken from slot offsets 0, 1, 4, 5, 8 and 9 and form address bits [47:40], [39:32], [31:24], [23:16], [15:8] and [7:0] in that order; bytes at other offsets have no effect on the stored address.
- R3: A slot whose extracted address has bit 40 set (the least significant bit of its first byte, the group bit) is not stored.
- R4: The first byte of a setup frame empties the table. Each unicast slot address is then appended at the next index in slot order, up to 16 entries.
- R5: When promisc_en is high at the strobe, the verdict is accept.
- R6: A destination with bit 40 set (multicast, including all-ones broadcast) is always accepted.
- R7: Any other destination is accepted only if it equals a table entry whose index is below the current fill count. Entries at or above the count, including stale ones from an earlier load, never match.
- R8: A dst_valid strobe taken while lookup_ready is high gives verdict_valid high on the next cycle, with verdict_accept valid in that same cycle. Without such a strobe, verdict_valid is low.
- R9: lookup_ready is low in any cycle with setup_valid high, and in any cycle where a setup frame has started but its 192nd byte has not yet been taken. A strobe in such a cycle produces no verdict.
- R10: After reset the table is empty (a unicast destination is rejected), verdict_valid is low, and lookup_ready is high when setup_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| promisc_en | input | 1 | Accept-all mode |
| setup_valid | input | 1 | Setup byte present this cycle |
| setup_byte | input | 8 | Setup frame byte |
| lookup_ready | output | 1 | Lookup strobe will be taken this cycle |
| dst_valid | input | 1 | Destination lookup strobe |
| dst_addr | input | 48 | Destination address, first byte in [47:40] |
| verdict_valid | output | 1 | Verdict present (one cycle after strobe) |
| verdict_accept | output | 1 | 1 = keep frame, 0 = drop |

## Verification
The hardest state to reach is a table whose fill count is lower than the number of physically written entries. Only in that state can a wrongly gated stale entry give a false accept. The stimulus reaches it by loading a frame with two unicast slots and then a frame with one unicast slot placed in slot 1. It then probes both old addresses, and an all-zero address that matches the never-written entries. Lookups are also issued during a pause in the middle of a setup frame and alongside a setup byte, because a blocked lookup can only be seen at the ports in those cycles.

// File: rtl/afl_pkg.sv
package afl_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAC_BYTES = 6;
  localparam int MAC_W     = BYTE_W * MAC_BYTES;
  localparam int GROUP_BIT = MAC_W - BYTE_W;

  typedef logic [MAC_W-1:0] mac_t;

  function automatic logic is_group(input mac_t a);
    return a[GROUP_BIT];
  endfunction
endpackage

// File: rtl/afl_slot_loader.sv
module afl_slot_loader import afl_pkg::*; #(
  parameter int NUM_SLOTS   = 16,
  parameter int SLOT_BYTES  = 12,
  parameter int PAIR_STRIDE = 4,
  parameter int PAIR_LEN    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              setup_valid,
  input  logic [BYTE_W-1:0] setup_byte,
  output logic              clr_o,
  output logic              wr_o,
  output mac_t              wr_mac_o,
  output logic              busy_o
);
  localparam int OFF_W     = (SLOT_BYTES > 1) ? $clog2(SLOT_BYTES) : 1;
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int LAST_PICK = (MAC_BYTES / PAIR_LEN - 1) * PAIR_STRIDE + PAIR_LEN - 1;

  logic [OFF_W-1:0]        off_q;
  logic [SLOT_W-1:0]       slot_q;
  logic                    mid_q;
  logic [MAC_W-BYTE_W-1:0] sr_q;

  int   off_i;
  logic pick;
  logic last_off;
  logic last_slot;
  mac_t mac_full;

  always_comb begin
    off_i     = int'(off_q);
    pick      = ((off_i % PAIR_STRIDE) < PAIR_LEN) && (off_i <= LAST_PICK);
    last_off  = (off_q == OFF_W'(SLOT_BYTES - 1));
    last_slot = (slot_q == SLOT_W'(NUM_SLOTS - 1));
    mac_full  = {sr_q, setup_byte};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q  <= '0;
      slot_q <= '0;
      mid_q  <= 1'b0;
      sr_q   <= '0;
    end else if (setup_valid) begin
      if (pick) sr_q <= mac_full[MAC_W-BYTE_W-1:0];
      if (last_off) begin
        off_q  <= '0;
        slot_q <= last_slot ? '0 : slot_q + 1'b1;
      end else begin
        off_q <= off_q + 1'b1;
      end
      mid_q <= !(last_off && last_slot);
    end
  end

  assign clr_o    = setup_valid && !mid_q;
  assign wr_o     = setup_valid && (off_i == LAST_PICK) && !is_group(mac_full);
  assign wr_mac_o = mac_full;
  assign busy_o   = setup_valid || mid_q;
endmodule

// File: rtl/afl_addr_table.sv
module afl_addr_table import afl_pkg::*; #(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic wr,
  input  mac_t wr_mac,
  input  mac_t lookup_mac,
  output logic hit
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  mac_t             entry_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [DEPTH-1:0] hit_vec;
  logic             room;

  assign room = (cnt_q < CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= '0;
    else if (clr)        cnt_q <= '0;
    else if (wr && room) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr && room) entry_q[cnt_q[IDX_W-1:0]] <= wr_mac;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_vec[i] = (CNT_W'(i) < cnt_q) && (entry_q[i] == lookup_mac);
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/afl_verdict.sv
module afl_verdict (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic promisc,
  input  logic group,
  input  logic hit,
  output logic vld_o,
  output logic acc_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      acc_o <= 1'b0;
    end else begin
      vld_o <= fire;
      if (fire) acc_o <= promisc || group || hit;
    end
  end
endmodule

// File: rtl/setup_addr_filter.sv
module setup_addr_filter #(
  parameter int NUM_SLOTS   = 16,
  parameter int SLOT_BYTES  = 12,
  parameter int PAIR_STRIDE = 4,
  parameter int PAIR_LEN    = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        promisc_en,
  input  logic        setup_valid,
  input  logic [7:0]  setup_byte,
  output logic        lookup_ready,
  input  logic        dst_valid,
  input  logic [47:0] dst_addr,
  output logic        verdict_valid,
  output logic        verdict_accept
);
  localparam int TABLE_DEPTH = NUM_SLOTS;

  logic          tbl_clr;
  logic          tbl_wr;
  afl_pkg::mac_t tbl_mac;
  logic          load_busy;
  logic          tbl_hit;
  logic          fire;

  afl_slot_loader #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES),
    .PAIR_STRIDE(PAIR_STRIDE), .PAIR_LEN(PAIR_LEN)
  ) u_loader (
    .clk(clk), .rst(rst), .setup_valid(setup_valid), .setup_byte(setup_byte),
    .clr_o(tbl_clr), .wr_o(tbl_wr), .wr_mac_o(tbl_mac), .busy_o(load_busy)
  );

  afl_addr_table #(.DEPTH(TABLE_DEPTH)) u_table (
    .clk(clk), .rst(rst), .clr(tbl_clr), .wr(tbl_wr), .wr_mac(tbl_mac),
    .lookup_mac(dst_addr), .hit(tbl_hit)
  );

  assign lookup_ready = !load_busy;
  assign fire         = dst_valid && lookup_ready;

  afl_verdict u_verdict (
    .clk(clk), .rst(rst), .fire(fire), .promisc(promisc_en),
    .group(afl_pkg::is_group(dst_addr)), .hit(tbl_hit),
    .vld_o(verdict_valid), .acc_o(verdict_accept)
  );
endmodule

// File: rtl/setup_addr_filter_chk.sv
module setup_addr_filter_chk (
  input logic clk,
  input logic rst,
  input logic promisc_en,
  input logic setup_valid,
  input logic dst_valid,
  input logic dst_group,
  input logic lookup_ready,
  input logic verdict_valid,
  input logic verdict_accept
);
  AST_BUSY_WHILE_LOADING: assert property (@(posedge clk) disable iff (rst)
    setup_valid |-> !lookup_ready); // R9
  AST_BLOCKED_NO_VERDICT: assert property (@(posedge clk) disable iff (rst)
    (dst_valid && !lookup_ready) |=> !verdict_valid); // R9
  AST_VERDICT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (dst_valid && lookup_ready) |=> verdict_valid); // R8
  AST_VERDICT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    verdict_valid |-> $past(dst_valid)); // R8
  AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (dst_valid && lookup_ready && promisc_en) |=> verdict_accept); // R5
  AST_GROUP_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (dst_valid && lookup_ready && dst_group) |=> verdict_accept); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !verdict_valid); // R10
endmodule

bind setup_addr_filter setup_addr_filter_chk u_chk (
  .clk(clk), .rst(rst), .promisc_en(promisc_en), .setup_valid(setup_valid),
  .dst_valid(dst_valid), .dst_group(dst_addr[40]), .lookup_ready(lookup_ready),
  .verdict_valid(verdict_valid), .verdict_accept(verdict_accept)
);

// File: tb/setup_addr_filter_bench.sv
`timescale 1ns/1ps
module setup_addr_filter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        promisc_en = 1'b0;
  logic        setup_valid = 1'b0;
  logic [7:0]  setup_byte = '0;
  logic        lookup_ready;
  logic        dst_valid = 1'b0;
  logic [47:0] dst_addr = '0;
  logic        verdict_valid;
  logic        verdict_accept;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [47:0] frame_mac [16];

  always #2 clk = ~clk;

  setup_addr_filter u_setup_addr_filter (
    .clk(clk), .rst(rst), .promisc_en(promisc_en), .setup_valid(setup_valid),
    .setup_byte(setup_byte), .lookup_ready(lookup_ready), .dst_valid(dst_valid),
    .dst_addr(dst_addr), .verdict_valid(verdict_valid), .verdict_accept(verdict_accept)
  );

  // {promisc, expected accept, destination}, checked after frame A
  localparam int NV = 10;
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 1'b1, 48'h02_11_22_33_44_55},
    {1'b0, 1'b1, 48'h00_AA_BB_CC_DD_EE},
    {1'b0, 1'b0, 48'h00_AA_BB_CC_DD_EF},
    {1'b0, 1'b1, 48'h01_00_5E_00_00_01},
    {1'b0, 1'b1, 48'hFF_FF_FF_FF_FF_FF},
    {1'b0, 1'b0, 48'h02_11_22_33_44_54},
    {1'b1, 1'b1, 48'h06_00_00_00_00_01},
    {1'b0, 1'b0, 48'h06_00_00_00_00_01},
    {1'b0, 1'b1, 48'h03_00_00_00_00_00},
    {1'b0, 1'b0, 48'h00_00_00_00_00_00}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] frame_byte(input int idx);
    int s, o, p;
    s = idx / 12;
    o = idx % 12;
    if ((o % 4) < 2 && o <= 9) begin
      p = (o / 4) * 2 + (o % 4);
      return frame_mac[s][47 - 8*p -: 8];
    end
    return 8'hC0 + 8'(o);
  endfunction

  // probe_gap: pause before that byte and try a lookup; probe_busy: lookup alongside that byte
  task automatic send_frame(input int probe_gap, input int probe_busy);
    for (int i = 0; i < 192; i++) begin
      if (i == probe_gap) begin
        @(negedge clk);
        setup_valid = 1'b0;
        dst_valid = 1'b1;
        dst_addr = 48'h02_11_22_33_44_55;
        #0.1;
        check(lookup_ready == 1'b0, "R9 ready during gap", 64'(lookup_ready), 64'd0);
        @(negedge clk);
        dst_valid = 1'b0;
        check(verdict_valid == 1'b0, "R9 no verdict in gap", 64'(verdict_valid), 64'd0);
      end
      @(negedge clk);
      setup_valid = 1'b1;
      setup_byte = frame_byte(i);
      if (i == probe_busy) begin
        dst_valid = 1'b1;
        dst_addr = 48'hFF_FF_FF_FF_FF_FF;
        #0.1;
        check(lookup_ready == 1'b0, "R9 ready with setup byte", 64'(lookup_ready), 64'd0);
      end else begin
        dst_valid = 1'b0;
      end
      if (i == probe_busy + 1)
        check(verdict_valid == 1'b0, "R9 no verdict with setup byte", 64'(verdict_valid), 64'd0);
    end
    @(negedge clk);
    setup_valid = 1'b0;
    dst_valid = 1'b0;
    #0.1;
    check(lookup_ready == 1'b1, "R1 ready after 192 bytes", 64'(lookup_ready), 64'd1);
  endtask

  task automatic lookup(input logic p, input logic [47:0] a, input logic exp, input string req);
    @(negedge clk);
    promisc_en = p;
    dst_valid = 1'b1;
    dst_addr = a;
    @(negedge clk);
    dst_valid = 1'b0;
    promisc_en = 1'b0;
    check(verdict_valid == 1'b1, req, 64'(verdict_valid), 64'd1);
    check(verdict_accept == exp, req, 64'(verdict_accept), 64'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(verdict_valid == 1'b0, "R10 verdict low in reset", 64'(verdict_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(lookup_ready == 1'b1, "R10 ready after reset", 64'(lookup_ready), 64'd1);
    check(verdict_valid == 1'b0, "R8 no verdict without strobe", 64'(verdict_valid), 64'd0);
    lookup(1'b0, 48'h00_00_00_00_00_00, 1'b0, "R10 empty table rejects");

    // frame A: two unicast slots, group slots elsewhere (R2, R3)
    for (int s = 0; s < 16; s++) frame_mac[s] = 48'hFF_FF_FF_FF_FF_FF;
    frame_mac[0] = 48'h02_11_22_33_44_55;
    frame_mac[1] = 48'h01_00_5E_00_00_01;
    frame_mac[2] = 48'h00_AA_BB_CC_DD_EE;
    send_frame(50, 120);

    for (int v = 0; v < NV; v++)
      lookup(VEC[v][49], VEC[v][47:0], VEC[v][48], "R2 R3 R5 R6 R7 vector");

    // frame B: one unicast in slot 1, so index 1 is stale (R4, R7)
    for (int s = 0; s < 16; s++) frame_mac[s] = 48'hFF_FF_FF_FF_FF_FF;
    frame_mac[1] = 48'h00_12_34_56_78_9A;
    send_frame(-1, -1);
    lookup(1'b0, 48'h00_12_34_56_78_9A, 1'b1, "R4 new entry accepted");
    lookup(1'b0, 48'h00_AA_BB_CC_DD_EE, 1'b0, "R7 stale entry rejected");
    lookup(1'b0, 48'h02_11_22_33_44_55, 1'b0, "R4 old entry dropped");

    // frame C: full table of 16 (R4)
    for (int s = 0; s < 16; s++) frame_mac[s] = {40'h00_00_00_00_10, 8'(s)};
    send_frame(-1, -1);
    lookup(1'b0, 48'h00_00_00_00_10_00, 1'b1, "R4 first of 16");
    lookup(1'b0, 48'h00_00_00_00_10_0F, 1'b1, "R4 last of 16");
    lookup(1'b0, 48'h00_00_00_00_10_10, 1'b0, "R7 beyond table");

    // back-to-back strobes (R8)
    @(negedge clk);
    dst_valid = 1'b1;
    dst_addr = 48'h00_00_00_00_10_05;
    @(negedge clk);
    dst_addr = 48'h00_00_00_00_20_05;
    check(verdict_valid && verdict_accept, "R8 first of pair", {62'd0, verdict_valid, verdict_accept}, 64'd3);
    @(negedge clk);
    dst_valid = 1'b0;
    check(verdict_valid && !verdict_accept, "R8 second of pair", {62'd0, verdict_valid, verdict_accept}, 64'd2);
    @(negedge clk);
    check(verdict_valid == 1'b0, "R8 verdict drops", 64'(verdict_valid), 64'd0);

    // reset empties table (R10)
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    lookup(1'b0, 48'h00_00_00_00_10_00, 1'b0, "R10 reset clears table");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule